// File: doc/BRIEF.md
# Bitmap-Driven CCD Clock Sequencer

This block produces a set of parallel digital clock lines for a CCD readout chain by replaying bit patterns kept in on-chip RAM. Every RAM word is one time slot, and every bit of the word sets one output line high (1) or low (0). A host first fills the pattern RAM through a write port whose address advances by itself after each word. It then programs the timing and geometry registers and issues a start pulse.

During playback, a horizontal pattern region is replayed once per pixel. After the last pixel of a line, a separate vertical pattern region is replayed once. This repeats for the programmed number of lines. Each word stays on the outputs for a programmable number of clock cycles, and the horizontal and vertical regions have their own hold times. When the frame ends, a one-cycle done pulse is given and the outputs settle on the word stored at address 0.

The address logic therefore works in two modes: a download mode that writes the RAM, and a playback mode that reads it. The mode controls which host actions are accepted.

Top module: `bitmap_clock_seq`

## Requirements
- R1: While reset is applied and right after it, `clkOut` is 0, and `done` and `busy` are low.
- R2: Download mode is entered when `dlMode` is high while the block is idle, and left when `dlMode` goes low. In download mode, a write with `cfgSel`=0 loads the pattern pointer from `cfgData[10:0]`. A write with `cfgSel`=1 stores `cfgData` at the pointer and then advances the pointer, wrapping from 1535 to 0.
- R3: A `start` pulse is ignored while the block is in download mode, and `busy` stays low.
- R4: All register writes are dropped while playback is busy. Pattern writes and pointer loads are also dropped outside download mode. The configuration select codes are: 2 horizontal hold, 3 vertical hold, 4 pixels per line, 5 lines per frame, 6 horizontal start, 7 horizontal length, 8 vertical start, 9 vertical length.
- R5: Bit i of `clkOut` equals bit i of the RAM word that plays in the current slot. If `start` is sampled at edge E0, slot k of the frame appears on `clkOut` after edge E(k+1).
- R6: A line consists of the horizontal region (from the horizontal start address, for the horizontal length in words) played once per pixel. Each word is held for the horizontal hold count in cycles.
- R7: After the last pixel of each line, the vertical region plays once, and each of its words is held for the vertical hold count.
- R8: After the vertical region of the last line, `done` is high for exactly one cycle, in the cycle that shows the frame's last slot. In the next cycle `clkOut` shows the word at address 0 and holds it.
- R9: A value of 0 in any hold, length, pixel or line register behaves as 1.
- R10: `busy` is high from the cycle after an accepted start through the cycle before `done`. Raising `dlMode` during playback does not alter or interrupt the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dlMode | input | 1 | Requests download mode while idle |
| start | input | 1 | Start-of-frame pulse |
| cfgWe | input | 1 | Register or pattern write strobe |
| cfgSel | input | 4 | Write target select |
| cfgData | input | 16 | Write data |
| clkOut | output | 16 | Clock line levels |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Playback in progress |

## Verification
The bench builds the expected slot stream from its own shadow of the pattern RAM and compares it against `clkOut` on every cycle. This catches an off-by-one hold count, a missing or extra horizontal repeat, or a vertical pass placed at the wrong point. It also checks that zero-valued registers play exactly one slot, which a design without that treatment would turn into a 2^n-cycle stall. A pointer wrap run places words across the top of the RAM, so a missed wrap shows up as wrong data. Writes and a download request are issued in the middle of a frame, and the frame is then replayed unchanged; a design that let them through would either corrupt the pattern or change the line count. The bench also checks the timing of the done pulse and the return to word 0.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 1536;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int HOLD_W = 8;
  localparam int CNT_W  = 12;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_PTR    = 4'd0,
    SEL_PAT    = 4'd1,
    SEL_HHOLD  = 4'd2,
    SEL_VHOLD  = 4'd3,
    SEL_PIX    = 4'd4,
    SEL_LINES  = 4'd5,
    SEL_HSTART = 4'd6,
    SEL_HLEN   = 4'd7,
    SEL_VSTART = 4'd8,
    SEL_VLEN   = 4'd9
  } cfgSel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_HRUN, ST_VRUN} seqState_e;

  typedef struct packed {
    logic              ptrLoad;
    logic              patWr;
    logic              jump;
    logic              step;
    logic              show;
    logic [ADDR_W-1:0] target;
  } seqStrobe_t;
endpackage

// File: rtl/bcs_control.sv
module bcs_control
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dlMode,
  input  logic              start,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  output seqStrobe_t        stb,
  output logic              done,
  output logic              busy
);
  seqState_e         state;
  logic [HOLD_W-1:0] hHold, vHold, holdCnt;
  logic [CNT_W-1:0]  pixPerLine, linesPerFrame, pixCnt, lineCnt;
  logic [ADDR_W-1:0] hStart, hLen, vStart, vLen, wordIdx;
  logic              doneR;

  logic unusedCfgBits;
  assign unusedCfgBits = ^cfgData[WORD_W-1:CNT_W];

  logic              running, cfgOpen;
  logic [HOLD_W-1:0] curHold;
  logic [ADDR_W-1:0] curLen;
  logic              lastHold, lastWord, lastPix, lastLine;

  assign running  = (state == ST_HRUN) || (state == ST_VRUN);
  assign cfgOpen  = !running;
  assign curHold  = (state == ST_VRUN) ? vHold : hHold;
  assign curLen   = (state == ST_VRUN) ? vLen : hLen;
  // zero in any count register behaves as one (R9)
  assign lastHold = ({1'b0, holdCnt} + (HOLD_W+1)'(1)) >= {1'b0, curHold};
  assign lastWord = ({1'b0, wordIdx} + (ADDR_W+1)'(1)) >= {1'b0, curLen};
  assign lastPix  = ({1'b0, pixCnt} + (CNT_W+1)'(1)) >= {1'b0, pixPerLine};
  assign lastLine = ({1'b0, lineCnt} + (CNT_W+1)'(1)) >= {1'b0, linesPerFrame};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hHold <= '0; vHold <= '0; pixPerLine <= '0; linesPerFrame <= '0;
      hStart <= '0; hLen <= '0; vStart <= '0; vLen <= '0;
    end else if (cfgWe && cfgOpen) begin
      case (cfgSel)
        SEL_HHOLD:  hHold         <= cfgData[HOLD_W-1:0];
        SEL_VHOLD:  vHold         <= cfgData[HOLD_W-1:0];
        SEL_PIX:    pixPerLine    <= cfgData[CNT_W-1:0];
        SEL_LINES:  linesPerFrame <= cfgData[CNT_W-1:0];
        SEL_HSTART: hStart        <= cfgData[ADDR_W-1:0];
        SEL_HLEN:   hLen          <= cfgData[ADDR_W-1:0];
        SEL_VSTART: vStart        <= cfgData[ADDR_W-1:0];
        SEL_VLEN:   vLen          <= cfgData[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; holdCnt <= '0; wordIdx <= '0;
      pixCnt <= '0; lineCnt <= '0; doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (dlMode) state <= ST_LOAD;
          else if (start) begin
            state <= ST_HRUN; holdCnt <= '0; wordIdx <= '0;
            pixCnt <= '0; lineCnt <= '0;
          end
        end
        ST_LOAD: if (!dlMode) state <= ST_IDLE;
        ST_HRUN: begin
          if (!lastHold) holdCnt <= holdCnt + HOLD_W'(1);
          else begin
            holdCnt <= '0;
            if (!lastWord) wordIdx <= wordIdx + ADDR_W'(1);
            else begin
              wordIdx <= '0;
              if (lastPix) begin pixCnt <= '0; state <= ST_VRUN; end
              else pixCnt <= pixCnt + CNT_W'(1);
            end
          end
        end
        ST_VRUN: begin
          if (!lastHold) holdCnt <= holdCnt + HOLD_W'(1);
          else begin
            holdCnt <= '0;
            if (!lastWord) wordIdx <= wordIdx + ADDR_W'(1);
            else begin
              wordIdx <= '0;
              if (lastLine) begin state <= ST_IDLE; doneR <= 1'b1; end
              else begin lineCnt <= lineCnt + CNT_W'(1); state <= ST_HRUN; end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.ptrLoad = cfgWe && (cfgSel == SEL_PTR) && (state == ST_LOAD);
    stb.patWr   = cfgWe && (cfgSel == SEL_PAT) && (state == ST_LOAD);
    stb.show    = running || doneR;
    case (state)
      ST_IDLE: if (!dlMode && start) begin stb.jump = 1'b1; stb.target = hStart; end
      ST_HRUN: if (lastHold) begin
        if (lastWord) begin stb.jump = 1'b1; stb.target = lastPix ? vStart : hStart; end
        else stb.step = 1'b1;
      end
      ST_VRUN: if (lastHold) begin
        if (lastWord) begin stb.jump = 1'b1; stb.target = lastLine ? '0 : hStart; end
        else stb.step = 1'b1;
      end
      default: ;
    endcase
  end

  assign done = doneR;
  assign busy = running;
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [WORD_W-1:0] cfgData,
  output logic [WORD_W-1:0] clkOut
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [WORD_W-1:0] patMem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdAddr;

  logic unusedDataBits;
  assign unusedDataBits = ^cfgData[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (stb.patWr) patMem[wrPtr] <= cfgData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdAddr <= '0;
      clkOut <= '0;
    end else begin
      if (stb.ptrLoad) wrPtr <= cfgData[ADDR_W-1:0];
      else if (stb.patWr) wrPtr <= (wrPtr == LAST_ADDR) ? '0 : wrPtr + ADDR_W'(1);

      if (stb.jump) rdAddr <= stb.target;
      else if (stb.step) rdAddr <= (rdAddr == LAST_ADDR) ? '0 : rdAddr + ADDR_W'(1);

      if (stb.show) clkOut <= patMem[rdAddr];
    end
  end
endmodule

// File: rtl/bitmap_clock_seq.sv
module bitmap_clock_seq
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dlMode,
  input  logic              start,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  output logic [WORD_W-1:0] clkOut,
  output logic              done,
  output logic              busy
);
  seqStrobe_t stb;

  bcs_control u_control (
    .clk(clk), .rstN(rstN), .dlMode(dlMode), .start(start),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .stb(stb), .done(done), .busy(busy)
  );

  bcs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgData(cfgData), .clkOut(clkOut)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic dlMode,
  input logic done,
  input logic busy
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  p_start_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && dlMode && !busy) |=> !busy);

  p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

bind bitmap_clock_seq bcs_checker u_bcsChecker (
  .clk(clk), .rstN(rstN), .start(start), .dlMode(dlMode), .done(done), .busy(busy)
);

// File: tb/bitmap_clock_seq_tb.sv
module bitmap_clock_seq_tb;
  logic        clk = 1'b0;
  logic        rstN, dlMode, start, cfgWe;
  logic [3:0]  cfgSel;
  logic [15:0] cfgData, clkOut;
  logic        done, busy;

  always #4 clk = ~clk;

  bitmap_clock_seq u_dut (
    .clk(clk), .rstN(rstN), .dlMode(dlMode), .start(start), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .clkOut(clkOut), .done(done), .busy(busy)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  logic [15:0] shadow [1536];
  int mHH, mVH, mPix, mLines, mHS, mHL, mVS, mVL;
  logic [15:0] expQ [$];

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(int sel, logic [15:0] d);
    cfgWe = 1'b1; cfgSel = sel[3:0]; cfgData = d;
    tick();
    cfgWe = 1'b0;
  endtask

  // R2: pointer load then auto-incrementing pattern writes in download mode
  task automatic loadWords(int base, int n);
    int p;
    dlMode = 1'b1; tick();
    writeReg(0, 16'(base));
    p = base;
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      writeReg(1, w);
      shadow[p] = w;
      p = (p == 1535) ? 0 : p + 1;
    end
    dlMode = 1'b0; tick();
  endtask

  task automatic setCfg(int hh, int vh, int pix, int ln, int hs, int hl, int vs, int vl);
    writeReg(2, 16'(hh)); writeReg(3, 16'(vh)); writeReg(4, 16'(pix));
    writeReg(5, 16'(ln)); writeReg(6, 16'(hs)); writeReg(7, 16'(hl));
    writeReg(8, 16'(vs)); writeReg(9, 16'(vl));
    mHH = hh; mVH = vh; mPix = pix; mLines = ln; mHS = hs; mHL = hl; mVS = vs; mVL = vl;
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected slot stream from R6, R7, R9
  function automatic void buildStream();
    expQ.delete();
    for (int l = 0; l < eff(mLines); l++) begin
      for (int p = 0; p < eff(mPix); p++)
        for (int w = 0; w < eff(mHL); w++)
          for (int h = 0; h < eff(mHH); h++) expQ.push_back(shadow[mHS + w]);
      for (int w = 0; w < eff(mVL); w++)
        for (int h = 0; h < eff(mVH); h++) expQ.push_back(shadow[mVS + w]);
    end
  endfunction

  task automatic runCheck(string tag, bit meddle);
    int T, bad, doneBad, busyBad;
    logic [15:0] firstAct, firstExp;
    buildStream();
    T = expQ.size();
    bad = 0; doneBad = 0; busyBad = 0; firstAct = '0; firstExp = '0;
    start = 1'b1; tick(); start = 1'b0;
    chk(busy === 1'b1, {"R10 busy after start ", tag}, 32'(busy), 1);
    for (int k = 0; k < T; k++) begin
      if (meddle) begin
        if (k == 0) begin dlMode = 1'b1; cfgWe = 1'b1; cfgSel = 4'd0; cfgData = 16'd5; end
        else if (k == 1) begin cfgSel = 4'd1; cfgData = 16'hBEEF; end
        else if (k == 2) begin cfgSel = 4'd5; cfgData = 16'd9; end
        else if (k == 3) cfgWe = 1'b0;
      end
      tick();
      if (clkOut !== expQ[k]) begin
        if (bad == 0) begin firstAct = clkOut; firstExp = expQ[k]; end
        bad++;
      end
      if (k == T - 1) chk(done === 1'b1, {"R8 done on last slot ", tag}, 32'(done), 1);
      else begin
        if (done !== 1'b0) doneBad++;
        if (busy !== 1'b1) busyBad++;
      end
    end
    chk(bad == 0, {"R5 R6 R7 slot stream ", tag}, 32'(firstAct), 32'(firstExp));
    chk(doneBad == 0, {"R8 no early done ", tag}, 32'(doneBad), 0);
    chk(busyBad == 0, {"R10 busy held ", tag}, 32'(busyBad), 0);
    tick();
    chk(clkOut === shadow[0], {"R8 return to word 0 ", tag}, 32'(clkOut), 32'(shadow[0]));
    chk(done === 1'b0 && busy === 1'b0, {"R8 done single cycle ", tag}, 32'({done, busy}), 0);
    if (meddle) begin dlMode = 1'b0; tick(); tick(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd7741));
    rstN = 1'b0; dlMode = 1'b0; start = 1'b0; cfgWe = 1'b0; cfgSel = '0; cfgData = '0;
    repeat (3) tick();
    chk(clkOut === 16'h0 && done === 1'b0 && busy === 1'b0, "R1 in reset",
        32'({clkOut, done, busy}), 0);
    rstN = 1'b1; tick();
    chk(clkOut === 16'h0 && done === 1'b0 && busy === 1'b0, "R1 after reset",
        32'({clkOut, done, busy}), 0);

    // R2 pointer wrap: words land at 1534, 1535, 0
    loadWords(1534, 3);
    setCfg(1, 2, 1, 1, 1534, 2, 0, 1);
    runCheck("r2_wrap", 1'b0);

    loadWords(0, 40);
    setCfg(1, 1, 1, 1, 7, 1, 12, 1);
    runCheck("minimal", 1'b0);

    // R9: all counts zero act as one
    setCfg(0, 0, 0, 0, 5, 0, 9, 0);
    runCheck("r9_zero", 1'b0);

    for (int i = 0; i < 5; i++) begin
      setCfg($urandom_range(3, 1), $urandom_range(3, 1), $urandom_range(3, 1),
             $urandom_range(3, 1), $urandom_range(30, 0), $urandom_range(5, 1),
             $urandom_range(30, 0), $urandom_range(4, 1));
      runCheck($sformatf("rand%0d", i), 1'b0);
    end

    // R3: start during download mode is ignored
    held = clkOut;
    dlMode = 1'b1; tick(); tick();
    start = 1'b1; tick(); start = 1'b0;
    begin
      int bz;
      bz = 0;
      for (int i = 0; i < 4; i++) begin
        tick();
        if (busy !== 1'b0 || clkOut !== held) bz++;
      end
      chk(bz == 0, "R3 start ignored in download mode", 32'(bz), 0);
    end
    dlMode = 1'b0; tick();

    // R4 R10: writes and download request during playback are dropped
    setCfg(2, 1, 2, 2, 3, 3, 20, 2);
    runCheck("r4_meddle", 1'b1);
    runCheck("r4_replay", 1'b0);

    // R4: pattern write outside download mode is dropped
    dlMode = 1'b1; tick();
    writeReg(0, 16'(mHS));
    dlMode = 1'b0; tick();
    writeReg(1, shadow[mHS] ^ 16'hA5A5);
    runCheck("r4_idle_write", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule